// File: doc/BRIEF.md
# Word-Level Link Synchronization Machine

This block watches the receive side of one serial lane whose 8b/10b characters have already been decoded and grouped into 4-character words. For each word it is told three things: that the word is present, whether its first character is a comma (which makes the word an idle ordered set), and whether any character of the word carried a code violation. A code violation covers running-disparity errors as well as commas found in an illegal position. From this stream the block decides whether the lane is word-synchronized and reports it as a pair of status flags.

Acquisition needs a run of ordered-set words free of violations. Once the lane is up, isolated violations are tolerated. Each violation raises an error level. A run of consecutive clean words after a violation lowers that level by one step, passing through a first-clean-word and a second-clean-word phase. Only when violations arrive faster than the clean runs can clear them does the block fall back to loss of sync. A synchronous power-up reset and a global enable both force the loss state.

Top module: `lsync_word_fsm`

## Requirements
- R1: A synchronous active-high `rst` sampled at a rising edge puts the block in loss of sync: `sync_ok`=0 and `los`=1 after that edge.
- R2: While `link_en` is 0 the block is held in loss of sync from the next edge on, all words are ignored, and any acquisition progress or error level is discarded.
- R3: An edge at which `word_vld` is 0 changes neither the outputs nor any internal progress.
- R4: Starting from loss of sync, the edge that accepts the ACQ_WORDS-th (default 3) word with `word_os`=1 and `word_cv`=0 drives `sync_ok` to 1 and `los` to 0.
- R5: During acquisition a word with `word_vld`=1, `word_os`=0, `word_cv`=0 neither advances nor clears acquisition progress.
- R6: During acquisition a word with `word_cv`=1 clears acquisition progress to zero, whether or not `word_os` is set.
- R7: While synchronized, each word with `word_cv`=1 raises the error level by one; the word that would raise it to LOSS_CV (default 4) instead drops the block to loss of sync.
- R8: While synchronized with a nonzero error level, CLEAR_WORDS (default 2) consecutive words with `word_cv`=0 lower the level by one; a violation in between restarts that count.
- R9: While synchronized, words with `word_cv`=0 count as clean regardless of `word_os`, and clean words at error level zero have no effect.
- R10: `los` is always the complement of `sync_ok`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Word clock |
| rst | input | 1 | Synchronous active-high power-up reset |
| link_en | input | 1 | Global enable of the state machine; 0 forces loss of sync |
| word_vld | input | 1 | A word is presented on this cycle |
| word_os | input | 1 | First character of the word is a comma (ordered set) |
| word_cv | input | 1 | At least one character of the word has a code violation |
| sync_ok | output | 1 | Word synchronization achieved |
| los | output | 1 | Loss of synchronization |

## Verification
The bench builds the block with its default thresholds: three ordered sets to acquire, a fourth outstanding violation to lose sync, and two clean words to clear one level. These small values put every transition (acquisition, the full climb of the error level, the exact clear boundary and loss) within a few words, so random traffic with a moderate violation rate crosses the sync and loss thresholds many times. Directed sequences pin the boundaries: the third ordered set, the fourth violation, a violation interleaved between clean words, and enable or reset arriving mid-acquisition and mid-sync.

// File: rtl/lsync_pkg.sv
package lsync_pkg;

    typedef enum logic {
        LNK_LOST = 1'b0,
        LNK_UP   = 1'b1
    } link_st_e;

    typedef struct packed {
        logic vld;
        logic os;
        logic cv;
    } word_in_t;

    // width needed to hold values 0 .. n-1
    function automatic int unsigned cnt_w(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

    function automatic logic acq_step(input word_in_t w);
        return w.vld && w.os && !w.cv;
    endfunction

    function automatic logic word_bad(input word_in_t w);
        return w.vld && w.cv;
    endfunction

    function automatic logic word_clean(input word_in_t w);
        return w.vld && !w.cv;
    endfunction

endpackage

// File: rtl/lsync_acq_ctr.sv
module lsync_acq_ctr #(
    parameter int unsigned ACQ_WORDS = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic step,
    input  logic kill,
    output logic done
);
    localparam int unsigned CW = lsync_pkg::cnt_w(ACQ_WORDS);
    localparam logic [CW-1:0] LAST = CW'(ACQ_WORDS - 1);

    logic [CW-1:0] cnt_q;

    assign done = step && !kill && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || clr || kill || done) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    p_acq_bound_r4: assert property (@(posedge clk) disable iff (rst)
        int'(cnt_q) < int'(ACQ_WORDS));

    p_kill_clears_r6: assert property (@(posedge clk) disable iff (rst)
        kill |=> (cnt_q == '0));

    p_idle_keeps_r5: assert property (@(posedge clk) disable iff (rst)
        !clr && !step && !kill |=> $stable(cnt_q));

endmodule

// File: rtl/lsync_err_track.sv
module lsync_err_track #(
    parameter int unsigned LOSS_CV     = 4,
    parameter int unsigned CLEAR_WORDS = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic bad,
    input  logic good,
    output logic lose
);
    localparam int unsigned LW = lsync_pkg::cnt_w(LOSS_CV);
    localparam int unsigned GW = lsync_pkg::cnt_w(CLEAR_WORDS);
    localparam logic [LW-1:0] LVL_TOP  = LW'(LOSS_CV - 1);
    localparam logic [GW-1:0] GOOD_TOP = GW'(CLEAR_WORDS - 1);

    logic [LW-1:0] lvl_q;
    logic [GW-1:0] good_q;

    assign lose = bad && (lvl_q == LVL_TOP);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            lvl_q  <= '0;
            good_q <= '0;
        end else if (bad) begin
            lvl_q  <= lose ? '0 : lvl_q + 1'b1;
            good_q <= '0;
        end else if (good && (lvl_q != '0)) begin
            if (good_q == GOOD_TOP) begin
                lvl_q  <= lvl_q - 1'b1;
                good_q <= '0;
            end else begin
                good_q <= good_q + 1'b1;
            end
        end
    end

    p_lvl_bound_r7: assert property (@(posedge clk) disable iff (rst)
        int'(lvl_q) < int'(LOSS_CV));

    p_bad_raises_r7: assert property (@(posedge clk) disable iff (rst)
        !clr && bad && !lose |=> (lvl_q == $past(lvl_q) + 1'b1));

    p_bad_restarts_r8: assert property (@(posedge clk) disable iff (rst)
        !clr && bad |=> (good_q == '0));

    p_floor_r9: assert property (@(posedge clk) disable iff (rst)
        !clr && !bad && (lvl_q == '0) |=> (lvl_q == '0) && (good_q == '0));

    p_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        !clr && !bad && !good |=> $stable(lvl_q) && $stable(good_q));

endmodule

// File: rtl/lsync_word_fsm.sv
module lsync_word_fsm #(
    parameter int unsigned ACQ_WORDS   = 3,
    parameter int unsigned LOSS_CV     = 4,
    parameter int unsigned CLEAR_WORDS = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic link_en,
    input  logic word_vld,
    input  logic word_os,
    input  logic word_cv,
    output logic sync_ok,
    output logic los
);
    import lsync_pkg::*;

    link_st_e state_q;
    word_in_t w;
    logic     in_lost;
    logic     acq_clr, acq_step_s, acq_kill, acq_done;
    logic     err_clr, err_bad, err_good, err_lose;

    assign w       = '{vld: word_vld, os: word_os, cv: word_cv};
    assign in_lost = (state_q == LNK_LOST);

    assign acq_clr    = !link_en || !in_lost;
    assign acq_step_s = in_lost && acq_step(w);
    assign acq_kill   = in_lost && word_bad(w);

    assign err_clr  = !link_en || in_lost;
    assign err_bad  = !in_lost && word_bad(w);
    assign err_good = !in_lost && word_clean(w);

    lsync_acq_ctr #(.ACQ_WORDS(ACQ_WORDS)) u_acq (
        .clk  (clk),
        .rst  (rst),
        .clr  (acq_clr),
        .step (acq_step_s),
        .kill (acq_kill),
        .done (acq_done)
    );

    lsync_err_track #(.LOSS_CV(LOSS_CV), .CLEAR_WORDS(CLEAR_WORDS)) u_err (
        .clk  (clk),
        .rst  (rst),
        .clr  (err_clr),
        .bad  (err_bad),
        .good (err_good),
        .lose (err_lose)
    );

    always_ff @(posedge clk) begin
        if (rst || !link_en) begin
            state_q <= LNK_LOST;
        end else begin
            case (state_q)
                LNK_LOST: if (acq_done) state_q <= LNK_UP;
                LNK_UP:   if (err_lose) state_q <= LNK_LOST;
                default:  state_q <= LNK_LOST;
            endcase
        end
    end

    assign sync_ok = (state_q == LNK_UP);
    assign los     = (state_q == LNK_LOST);

    p_en_low_los_r2: assert property (@(posedge clk) disable iff (rst)
        !link_en |=> los && !sync_ok);

    p_rise_needs_os_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(sync_ok) |-> $past(link_en && word_vld && word_os && !word_cv));

    p_fall_cause_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(sync_ok) && !$past(rst) |-> $past(!link_en || (word_vld && word_cv)));

    p_idle_hold_r3: assert property (@(posedge clk) disable iff (rst)
        link_en && !word_vld |=> $stable(sync_ok));

    p_flags_exclusive_r10: assert property (@(posedge clk) disable iff (rst)
        $countones({sync_ok, los}) == 1);

endmodule

// File: tb/tb_lsync_word_fsm.sv
`timescale 1ns/1ps
module tb_lsync_word_fsm;
    localparam int ACQ = 3;
    localparam int LOSSN = 4;
    localparam int CLR = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic link_en = 1'b0;
    logic word_vld = 1'b0;
    logic word_os = 1'b0;
    logic word_cv = 1'b0;
    logic sync_ok, los;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    // reference model state
    bit m_sync = 1'b0;
    int m_acq = 0;
    int m_lvl = 0;
    int m_good = 0;

    always #2.5 clk = ~clk;

    lsync_word_fsm #(.ACQ_WORDS(ACQ), .LOSS_CV(LOSSN), .CLEAR_WORDS(CLR)) dut (
        .clk(clk), .rst(rst), .link_en(link_en), .word_vld(word_vld),
        .word_os(word_os), .word_cv(word_cv), .sync_ok(sync_ok), .los(los)
    );

    task automatic model_step(input bit r, input bit e, input bit v, input bit o, input bit c);
        if (r || !e) begin
            m_sync = 1'b0; m_acq = 0; m_lvl = 0; m_good = 0;
        end else if (v) begin
            if (!m_sync) begin
                if (c) m_acq = 0;
                else if (o) begin
                    if (m_acq + 1 == ACQ) begin
                        m_sync = 1'b1; m_acq = 0; m_lvl = 0; m_good = 0;
                    end else m_acq++;
                end
            end else begin
                if (c) begin
                    m_good = 0;
                    if (m_lvl + 1 == LOSSN) begin
                        m_sync = 1'b0; m_lvl = 0;
                    end else m_lvl++;
                end else if (m_lvl > 0) begin
                    if (m_good + 1 == CLR) begin
                        m_lvl--; m_good = 0;
                    end else m_good++;
                end
            end
        end
    endtask

    task automatic check_out(input string req);
        n_chk++;
        if (sync_ok !== m_sync) begin
            n_bad++;
            $display("FAIL %s: sync_ok actual=%b expected=%b at %0t", req, sync_ok, m_sync, $time);
        end
        n_chk++;
        if (los !== !m_sync) begin
            n_bad++;
            $display("FAIL %s/R10: los actual=%b expected=%b at %0t", req, los, !m_sync, $time);
        end
    endtask

    task automatic drive(input bit r, input bit e, input bit v, input bit o, input bit c,
                         input string req, input bit do_chk);
        rst = r; link_en = e; word_vld = v; word_os = o; word_cv = c;
        @(posedge clk);
        @(negedge clk);
        model_step(r, e, v, o, c);
        if (do_chk) check_out(req);
    endtask

    task automatic os_word(input string req);  drive(0, 1, 1, 1, 0, req, 1); endtask
    task automatic dat_word(input string req); drive(0, 1, 1, 0, 0, req, 1); endtask
    task automatic cv_word(input string req);  drive(0, 1, 1, 0, 1, req, 1); endtask
    task automatic idle(input string req);     drive(0, 1, 0, 0, 0, req, 1); endtask
    task automatic do_reset(input string req); drive(1, 1, 0, 0, 0, req, 1); endtask
    task automatic acquire(input string req);
        for (int i = 0; i < ACQ; i++) os_word(req);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset("R1");
        do_reset("R1");
        // R1/R10 reset state
        check_out("R1");

        // R4 / R5: two ordered sets, a data word, then the third ordered set
        os_word("R4");
        os_word("R4");
        dat_word("R5");
        idle("R3");
        os_word("R4");           // now synchronized

        // R3: idle cycles keep sync
        for (int i = 0; i < 5; i++) idle("R3");

        // R7: three violations tolerated, the fourth loses sync
        cv_word("R7"); cv_word("R7"); cv_word("R7");
        idle("R3");
        cv_word("R7");

        // R6: violation during acquisition restarts progress
        os_word("R6"); os_word("R6"); drive(0, 1, 1, 1, 1, "R6", 1);
        os_word("R6"); os_word("R6");
        os_word("R6");           // third after the restart: sync

        // R8: one violation cleared by two clean words, then three more survive
        cv_word("R8"); dat_word("R8"); os_word("R8");
        cv_word("R8"); cv_word("R8"); cv_word("R8");
        // level 3 now; clear down with pairs, interleaved idle
        dat_word("R8"); idle("R3"); dat_word("R8");
        dat_word("R8"); dat_word("R8");
        dat_word("R8"); dat_word("R8");
        // R8: violation between clean words restarts count -> loss on fourth
        cv_word("R8"); dat_word("R8"); cv_word("R8"); dat_word("R8");
        cv_word("R8"); dat_word("R8"); cv_word("R8");

        // R9: clean words at level zero do not bank credit
        acquire("R9");
        for (int i = 0; i < 6; i++) dat_word("R9");
        cv_word("R9"); cv_word("R9"); cv_word("R9");
        cv_word("R9");

        // R2: enable low drops sync and ignores words
        acquire("R2");
        drive(0, 0, 1, 1, 0, "R2", 1);
        drive(0, 0, 1, 1, 0, "R2", 1);
        drive(0, 0, 1, 1, 0, "R2", 1);
        drive(0, 0, 1, 1, 0, "R2", 1);
        os_word("R2"); os_word("R2");
        // R2: enable pulse mid-acquisition discards progress
        drive(0, 0, 0, 0, 0, "R2", 1);
        os_word("R2"); os_word("R2");
        os_word("R2");
        // R2: error level discarded by enable low
        cv_word("R2"); cv_word("R2"); cv_word("R2");
        drive(0, 0, 0, 0, 0, "R2", 1);
        acquire("R2");
        cv_word("R2"); cv_word("R2"); cv_word("R2");

        // R1: reset while synchronized
        do_reset("R1");
        idle("R1");

        // constrained random traffic
        void'($urandom(32'h5EED_0011));
        for (int i = 0; i < 20000; i++) begin
            bit r, e, v, o, c;
            r = ($urandom % 800) == 0;
            e = ($urandom % 64) != 0;
            v = ($urandom % 4) != 0;
            o = ($urandom % 2) == 0;
            c = ($urandom % 10) == 0;
            drive(r, e, v, o, c, "R7/R8/R4", 1);
        end

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule